// File: doc/BRIEF.md
# Streaming Insertion Sorter for Candidate Lists

This block ranks the candidate list coming out of a list detector's final distance stage. Candidates arrive one per clock as a distance with a tag. Each new distance is compared with every stored distance in the same cycle and written into its rank slot, so the sorting register is always in ascending order. The register holds at most `DEPTH` entries. Once it is full, a candidate that is larger than every stored one is dropped. Candidates with equal distances keep their arrival order.

The modulation mode, sampled with the first candidate of a list, sets how long the list is. QPSK lists have 16 candidates. 16-QAM lists have 256; in that mode the register fills during the first 64 and then switches to a trimming phase. When the list is complete, the whole register moves in one cycle into a separate output shift register and is cleared for the next list. The output register then emits either the full ranked list or only its best K entries, one per clock, and marks the final entry of each list. An input stage of one register, together with the output register, sets the latency from first input to first output at 18 clocks for QPSK lists and 258 clocks for 16-QAM lists.

Top module: `cand_insert_sorter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: Within one list, the output distances do not decrease. Each output tag is the tag that entered with that distance.
- R3: Candidates with equal distances are emitted in the order in which they were accepted.
- R4: With `mode_i`=0 (QPSK) on a list's first candidate, the list is 16 candidates long and all 16 are kept and ranked.
- R5: With `mode_i`=1 (16-QAM) on a list's first candidate, the list is 256 candidates long. The 64 smallest are kept and the rest are discarded.
- R6: `in_ready_o` is low only while a completed list waits for its transfer. This is exactly one cycle per list when the output register is idle. A candidate presented while `in_ready_o` is low is not taken, and it is accepted once when `in_ready_o` returns high.
- R7: When the output register is idle, the first output appears 18 clocks after the clock edge that accepts a QPSK list's first candidate, and 258 clocks after it for a 16-QAM list.
- R8: `k_i`, sampled at the transfer, sets the number of entries emitted. A value of 0 or a value above the kept list size (16 or 64) gives the full kept list; otherwise exactly `k_i` entries are emitted. `out_last_o` is 1 on the final entry only.
- R9: Every list starts from an empty register, so nothing from the previous list appears in the output. The all-ones distance is a real value and is ranked and emitted like any other.
- R10: A completed list does not transfer while the output register is still emitting the previous list. `in_ready_o` stays low until the transfer, and both lists come out intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | List mode sampled with a list's first candidate: 0 = QPSK (16), 1 = 16-QAM (256) |
| k_i | input | 7 | Number of best entries to emit; 0 = full kept list |
| in_valid_i | input | 1 | Candidate present |
| in_dist_i | input | 20 | Candidate accumulated distance |
| in_tag_i | input | 32 | Candidate tag |
| in_ready_o | output | 1 | Candidate is taken at the next edge when high |
| out_valid_o | output | 1 | Ranked entry present |
| out_dist_o | output | 20 | Ranked entry distance |
| out_tag_o | output | 32 | Ranked entry tag |
| out_last_o | output | 1 | Final entry of the emitted list |

## Verification
The bench builds the block with its default parameters: 64 slots, 20-bit distances, 32-bit tags, and lists of 16 and 256. With these values the trimming phase and the discarding of candidates beyond the 64th are exercised, and the real latencies of 18 and 258 clocks can be measured. Random distances drawn from a narrow range produce many ties. Directed lists cover the all-ones distance, truncation by `k_i`, and back-to-back lists, including a short list that follows a long one and so has to wait for the output register.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_TRIM = 2'd1,
    PH_XFER = 2'd2
  } phase_e;

  localparam logic MODE_QPSK  = 1'b0;
  localparam logic MODE_QAM16 = 1'b1;
endpackage

// File: rtl/cis_in_stage.sv
module cis_in_stage #(
  parameter int DIST_W = 20,
  parameter int TAG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              valid_o,
  output logic              mode_o,
  output logic [DIST_W-1:0] dist_o,
  output logic [TAG_W-1:0]  tag_o
);
  // holds its item while the core is in transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= 1'b0;
      dist_o  <= '0;
      tag_o   <= '0;
    end else if (ready_i) begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      dist_o  <= dist_i;
      tag_o   <= tag_i;
    end
  end
endmodule

// File: rtl/cis_ctrl.sv
module cis_ctrl
  import cis_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int QPSK_LEN = 16,
  parameter int QAM_LEN  = 256,
  parameter int CNT_W    = $clog2(QAM_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             item_valid_i,
  input  logic             item_mode_i,
  input  logic             out_idle_i,
  output logic             ins_o,
  output logic             xfer_wait_o,
  output logic             xfer_fire_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] list_len_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  assign list_len_o  = (mode_q == MODE_QAM16) ? CNT_W'(QAM_LEN) : CNT_W'(QPSK_LEN);
  assign xfer_wait_o = (cnt_q == list_len_o);
  assign xfer_fire_o = xfer_wait_o && out_idle_i;
  assign ins_o       = item_valid_i && !xfer_wait_o;

  always_comb begin
    if (xfer_wait_o)                  phase_o = PH_XFER;
    else if (cnt_q >= CNT_W'(DEPTH))  phase_o = PH_TRIM;
    else                              phase_o = PH_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_QPSK;
    end else begin
      if (xfer_fire_o)  cnt_q <= '0;
      else if (ins_o)   cnt_q <= cnt_q + 1'b1;
      // mode is fixed by the first candidate of a list
      if (ins_o && cnt_q == '0) mode_q <= item_mode_i;
    end
  end
endmodule

// File: rtl/cis_rank_array.sv
module cis_rank_array #(
  parameter int DEPTH  = 64,
  parameter int DIST_W = 20,
  parameter int TAG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ins_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [DIST_W-1:0] dist_o [DEPTH],
  output logic [TAG_W-1:0]  tag_o  [DEPTH],
  output logic [DEPTH-1:0]  occ_o
);
  localparam logic [DIST_W-1:0] DIST_MAX = '1;

  logic [DIST_W-1:0] dist_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DEPTH-1:0]  occ_q;
  logic [DEPTH-1:0]  le;       // slot stays: occupied and not larger than new
  logic [DEPTH-1:0]  prev_le;

  assign prev_le = {le[DEPTH-2:0], 1'b1};
  assign dist_o  = dist_q;
  assign tag_o   = tag_q;
  assign occ_o   = occ_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DIST_W-1:0] src_dist;
    logic [TAG_W-1:0]  src_tag;
    logic              src_occ;

    assign le[i] = occ_q[i] && (dist_q[i] <= dist_i);

    if (i == 0) begin : g_head
      assign src_dist = dist_q[0];
      assign src_tag  = tag_q[0];
      assign src_occ  = occ_q[0];
    end else begin : g_body
      assign src_dist = dist_q[i-1];
      assign src_tag  = tag_q[i-1];
      assign src_occ  = occ_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dist_q[i] <= DIST_MAX;
        tag_q[i]  <= '0;
        occ_q[i]  <= 1'b0;
      end else if (clear_i) begin
        dist_q[i] <= DIST_MAX;
        tag_q[i]  <= '0;
        occ_q[i]  <= 1'b0;
      end else if (ins_i && !le[i]) begin
        if (prev_le[i]) begin
          dist_q[i] <= dist_i;
          tag_q[i]  <= tag_i;
          occ_q[i]  <= 1'b1;
        end else begin
          dist_q[i] <= src_dist;
          tag_q[i]  <= src_tag;
          occ_q[i]  <= src_occ;
        end
      end
    end
  end
endmodule

// File: rtl/cis_out_sr.sv
module cis_out_sr #(
  parameter int DEPTH  = 64,
  parameter int DIST_W = 20,
  parameter int TAG_W  = 32,
  parameter int K_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [K_W-1:0]    count_i,
  input  logic [DIST_W-1:0] dist_i [DEPTH],
  input  logic [TAG_W-1:0]  tag_i  [DEPTH],
  output logic              idle_o,
  output logic              valid_o,
  output logic [DIST_W-1:0] dist_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              last_o
);
  logic [DIST_W-1:0] sr_dist [DEPTH];
  logic [TAG_W-1:0]  sr_tag  [DEPTH];
  logic [K_W-1:0]    rem_q;

  assign idle_o = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        sr_dist[i] <= '0;
        sr_tag[i]  <= '0;
      end
      rem_q   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      dist_o  <= '0;
      tag_o   <= '0;
    end else if (load_i) begin
      sr_dist <= dist_i;
      sr_tag  <= tag_i;
      rem_q   <= count_i;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (!idle_o) begin
      valid_o <= 1'b1;
      dist_o  <= sr_dist[0];
      tag_o   <= sr_tag[0];
      last_o  <= (rem_q == K_W'(1));
      rem_q   <= rem_q - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
        sr_dist[i] <= sr_dist[i+1];
        sr_tag[i]  <= sr_tag[i+1];
      end
      sr_dist[DEPTH-1] <= '0;
      sr_tag[DEPTH-1]  <= '0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/cand_insert_sorter.sv
module cand_insert_sorter
  import cis_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DIST_W   = 20,
  parameter int TAG_W    = 32,
  parameter int QPSK_LEN = 16,
  parameter int QAM_LEN  = 256,
  localparam int CNT_W   = $clog2(QAM_LEN + 1),
  localparam int K_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [K_W-1:0]    k_i,
  input  logic              in_valid_i,
  input  logic [DIST_W-1:0] in_dist_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DIST_W-1:0] out_dist_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              out_last_o
);
  logic              item_valid;
  logic              item_mode;
  logic [DIST_W-1:0] item_dist;
  logic [TAG_W-1:0]  item_tag;
  logic              ins;
  logic              xfer_wait;
  logic              xfer_fire;
  logic              out_idle;
  phase_e            phase;
  logic [CNT_W-1:0]  list_len;
  logic [K_W-1:0]    n_full;
  logic [K_W-1:0]    n_emit;
  logic [DIST_W-1:0] slot_dist [DEPTH];
  logic [TAG_W-1:0]  slot_tag  [DEPTH];
  logic [DEPTH-1:0]  slot_occ;

  assign in_ready_o = !xfer_wait;

  // kept list size, then K selection
  assign n_full = (list_len >= CNT_W'(DEPTH)) ? K_W'(DEPTH) : K_W'(list_len);
  assign n_emit = (k_i == '0 || k_i > n_full) ? n_full : k_i;

  cis_in_stage #(.DIST_W(DIST_W), .TAG_W(TAG_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (in_ready_o),
    .valid_i (in_valid_i),
    .mode_i  (mode_i),
    .dist_i  (in_dist_i),
    .tag_i   (in_tag_i),
    .valid_o (item_valid),
    .mode_o  (item_mode),
    .dist_o  (item_dist),
    .tag_o   (item_tag)
  );

  cis_ctrl #(
    .DEPTH(DEPTH), .QPSK_LEN(QPSK_LEN), .QAM_LEN(QAM_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .item_valid_i (item_valid),
    .item_mode_i  (item_mode),
    .out_idle_i   (out_idle),
    .ins_o        (ins),
    .xfer_wait_o  (xfer_wait),
    .xfer_fire_o  (xfer_fire),
    .phase_o      (phase),
    .list_len_o   (list_len)
  );

  cis_rank_array #(.DEPTH(DEPTH), .DIST_W(DIST_W), .TAG_W(TAG_W)) u_rank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (xfer_fire),
    .ins_i   (ins),
    .dist_i  (item_dist),
    .tag_i   (item_tag),
    .dist_o  (slot_dist),
    .tag_o   (slot_tag),
    .occ_o   (slot_occ)
  );

  cis_out_sr #(.DEPTH(DEPTH), .DIST_W(DIST_W), .TAG_W(TAG_W), .K_W(K_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (xfer_fire),
    .count_i (n_emit),
    .dist_i  (slot_dist),
    .tag_i   (slot_tag),
    .idle_o  (out_idle),
    .valid_o (out_valid_o),
    .dist_o  (out_dist_o),
    .tag_o   (out_tag_o),
    .last_o  (out_last_o)
  );
endmodule

// File: rtl/cis_sorter_chk.sv
module cis_sorter_chk
  import cis_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DIST_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_i,
  input logic              out_valid_i,
  input logic              out_last_i,
  input logic [DIST_W-1:0] out_dist_i,
  input phase_e            phase_i,
  input logic [DIST_W-1:0] slot_dist_i [DEPTH],
  input logic [DEPTH-1:0]  slot_occ_i
);
  AST_OUT_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_last_i |=> out_valid_i && (out_dist_i >= $past(out_dist_i))); // R2

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_i |-> out_valid_i); // R8

  AST_TRIM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_TRIM |-> &slot_occ_i); // R5

  AST_CLEAR_ON_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_i) |-> slot_occ_i == '0); // R9

  AST_XFER_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_XFER && out_valid_i && !out_last_i |=> !in_ready_i); // R10

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_pair
    AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_occ_i[i+1] |-> slot_dist_i[i] <= slot_dist_i[i+1]); // R2
    AST_OCC_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_occ_i[i+1] |-> slot_occ_i[i]); // R9
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_empty
    AST_EMPTY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_occ_i[i] |-> slot_dist_i[i] == '1); // R9
  end
endmodule

bind cand_insert_sorter cis_sorter_chk #(.DEPTH(DEPTH), .DIST_W(DIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_last_i  (out_last_o),
  .out_dist_i  (out_dist_o),
  .phase_i     (phase),
  .slot_dist_i (slot_dist),
  .slot_occ_i  (slot_occ)
);

// File: tb/tb_cand_insert_sorter.sv
`timescale 1ns/1ps
module tb_cand_insert_sorter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [6:0]  k = '0;
  logic        in_valid = 1'b0;
  logic [19:0] in_dist = '0;
  logic [31:0] in_tag = '0;
  logic        in_ready, out_valid, out_last;
  logic [19:0] out_dist;
  logic [31:0] out_tag;

  int checks = 0, errors = 0;
  int cyc = 0, low_cnt = 0;
  int in_cyc = 0, first_cyc = 0;
  bit await_first = 0;

  logic [19:0] s_dist [512];
  logic [31:0] s_tag  [512];
  logic [19:0] ed_q [$];
  logic [31:0] et_q [$];
  bit          el_q [$];
  string       er_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cand_insert_sorter dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .k_i(k),
    .in_valid_i(in_valid), .in_dist_i(in_dist), .in_tag_i(in_tag),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_dist_o(out_dist),
    .out_tag_o(out_tag), .out_last_o(out_last)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // collector
  always @(negedge clk) begin
    if (rst_n && !in_ready) low_cnt++;
    if (rst_n && out_valid) begin
      if (await_first) begin
        first_cyc = cyc;
        await_first = 0;
      end
      if (ed_q.size() == 0) begin
        check(0, $sformatf("R2 extra output dist %h tag %h, expected none", out_dist, out_tag));
      end else begin
        logic [19:0] d; logic [31:0] t; bit l; string r;
        d = ed_q.pop_front(); t = et_q.pop_front(); l = el_q.pop_front(); r = er_q.pop_front();
        check(out_dist == d && out_tag == t && out_last == l,
              $sformatf("%s dist %h tag %h last %b, expected dist %h tag %h last %b",
                        r, out_dist, out_tag, out_last, d, t, l));
      end
    end
  end

  // stable ranking, keep 64, then K selection
  task automatic build_exp(input int base, input int n, input bit qam, input int kk, input string req);
    logic [19:0] rd [64];
    logic [31:0] rt [64];
    int cnt = 0;
    int nfull, nem;
    for (int j = 0; j < n; j++) begin
      int p = 0;
      for (int m = 0; m < cnt; m++) if (rd[m] <= s_dist[base+j]) p++;
      if (p < 64) begin
        for (int m = (cnt < 64 ? cnt : 63); m > p; m--) begin
          rd[m] = rd[m-1]; rt[m] = rt[m-1];
        end
        rd[p] = s_dist[base+j]; rt[p] = s_tag[base+j];
        if (cnt < 64) cnt++;
      end
    end
    nfull = qam ? 64 : 16;
    nem = (kk == 0 || kk > nfull) ? nfull : kk;
    for (int i = 0; i < nem; i++) begin
      ed_q.push_back(rd[i]); et_q.push_back(rt[i]);
      el_q.push_back(i == nem - 1); er_q.push_back(req);
    end
  endtask

  task automatic send(input int base, input int n, input bit qam);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_dist = s_dist[base+j]; in_tag = s_tag[base+j]; mode = qam;
      while (!in_ready) @(negedge clk);
      if (j == 0) in_cyc = cyc;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0; in_dist = '0; in_tag = '0;
  endtask

  task automatic drain();
    while (ed_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic fill_rand(input int base, input int n, input int id, input int range);
    for (int j = 0; j < n; j++) begin
      s_dist[base+j] = 20'($urandom_range(0, range));
      s_tag[base+j]  = {16'(id), 16'(j)};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, expected run to finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0,
          $sformatf("R1 in reset ready %b valid %b, expected 1 0", in_ready, out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0,
          $sformatf("R1 after reset ready %b valid %b, expected 1 0", in_ready, out_valid));

    // R4 R2 R7: random QPSK list, full output
    k = 0; fill_rand(0, 16, 1, 1000);
    build_exp(0, 16, 0, 0, "R4");
    await_first = 1;
    send(0, 16, 0); idle_in(); drain();
    check(first_cyc - in_cyc == 19, $sformatf("R7 qpsk latency %0d, expected 18", first_cyc - in_cyc - 1));

    // R3: many ties
    for (int j = 0; j < 16; j++) begin
      s_dist[j] = 20'((j % 3) * 4); s_tag[j] = 32'h0300_0000 + 32'(j);
    end
    build_exp(0, 16, 0, 0, "R3"); send(0, 16, 0); idle_in(); drain();

    // R8: best 5 of QPSK
    k = 7'd5; fill_rand(0, 16, 3, 50);
    build_exp(0, 16, 0, 5, "R8"); send(0, 16, 0); idle_in(); drain();

    // R5 R7: random 16-QAM list
    k = 0; fill_rand(0, 256, 4, 5000);
    build_exp(0, 256, 1, 0, "R5");
    await_first = 1;
    send(0, 256, 1); idle_in(); drain();
    check(first_cyc - in_cyc == 259, $sformatf("R7 qam latency %0d, expected 258", first_cyc - in_cyc - 1));

    // R9: all-ones distances mixed with small ones
    for (int j = 0; j < 256; j++) begin
      s_dist[j] = (j % 5 == 0) ? 20'(j) : 20'hFFFFF; s_tag[j] = 32'h0500_0000 + 32'(j);
    end
    build_exp(0, 256, 1, 0, "R9"); send(0, 256, 1); idle_in(); drain();

    // R8: k above kept size gives 64; k=1 gives one
    k = 7'd100; fill_rand(0, 256, 6, 200);
    build_exp(0, 256, 1, 100, "R8"); send(0, 256, 1); idle_in(); drain();
    k = 7'd1; fill_rand(0, 16, 7, 200);
    build_exp(0, 16, 0, 1, "R8"); send(0, 16, 0); idle_in(); drain();

    // R6: two QPSK lists back to back
    k = 0; fill_rand(0, 16, 8, 300); fill_rand(16, 16, 9, 300);
    build_exp(0, 16, 0, 0, "R6"); build_exp(16, 16, 0, 0, "R6");
    low_cnt = 0;
    send(0, 16, 0); send(16, 16, 0); idle_in(); drain();
    check(low_cnt == 2, $sformatf("R6 ready low cycles %0d, expected 2", low_cnt));

    // R10: QPSK list right after a 16-QAM list
    fill_rand(0, 256, 10, 3000); fill_rand(256, 16, 11, 3000);
    build_exp(0, 256, 1, 0, "R10"); build_exp(256, 16, 0, 0, "R10");
    low_cnt = 0;
    send(0, 256, 1); send(256, 16, 0); idle_in(); drain();
    check(low_cnt > 2, $sformatf("R10 ready low cycles %0d, expected more than 2", low_cnt));

    check(out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("R6 idle ready %b valid %b, expected 1 0", in_ready, out_valid));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule